// File: doc/BRIEF.md
# Quad Serial RAM Transaction Engine

This block runs single transactions against one serial pseudo-static RAM that hangs on a four-line data bus with its own chip select and serial clock. A requester presents a command byte, a 24-bit address, a read/write flag, a line-width flag and a byte count. The engine then runs the command phase, an optional address phase, fixed read dummy cycles when they apply, and the data phase. Every phase goes out either one bit per serial clock on a single line (SPI) or one nibble per serial clock on all four lines (QPI). Write bytes are pulled from the requester one at a time, and read bytes are handed back one at a time.

The serial clock runs at half the system clock. Each serial clock period is two system cycles: low first, then high. Outgoing data changes on the falling edge, and incoming data is sampled at the end of the high half. A two-bit clock-mode input sets what happens around chip-select release. The clock can stop, give one or two extra pulses after release, or run all the time. Clock mode and extra dummy must be held stable while a transaction is in progress. A transaction with no address and no data sends only the command. Typical uses are mode switches and reset commands.

Top module: `quad_ram_engine`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, dq_oe is 0, and busy, done and rd_valid are all 0.
- R2: In SPI mode the 8-bit command and then the 24-bit address go out MSB first on dq_o[0], one bit per sclk rising edge, with dq_oe = 4'b0001.
- R3: In QPI mode the command, address and write data go out one nibble per sclk rising edge on dq_o[3:0], high nibble first, with dq_oe = 4'b1111.
- R4: A read that has an address phase inserts 6 + extra_dummy dummy sclk cycles after the address. The 6 comes from a stored minus-one value of 5. dq_oe is 0 during the dummy and read-data cycles.
- R5: A write has no dummy cycles. Write bytes follow the address in request order. Each byte is taken from wr_data when wr_take is high at a clock edge, exactly once per byte.
- R6: Read data is sampled on dq_i[1] MSB first in SPI mode, or on dq_i[3:0] high nibble first in QPI mode. Each assembled byte appears on rd_data with a one-cycle rd_valid pulse.
- R7: A request with req_addr_en = 0 and req_len = 0 produces only the command units: 8 in SPI, 2 in QPI.
- R8: cs_n falls with sclk low and the first command unit already driven, one system cycle before the first rising edge (no extra setup). After the last rising edge, cs_n stays low for one full sclk period with sclk low (one cycle of hold). cs_n only changes while sclk is low.
- R9: Clock mode 1 or 2 gives 1 or 2 sclk pulses after cs_n rises and before busy falls. In clock mode 0, sclk is low whenever cs_n is high.
- R10: In clock mode 3, sclk toggles on every system cycle, including while idle. There are no tail pulses, and the hold period carries one pulse.
- R11: busy is high in the cycle after a request is accepted while idle. It stays high until the tail is finished. done is a one-cycle pulse in the first cycle that busy is low.
- R12: A request presented while busy is ignored: it causes no extra chip-select frame and no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mode | input | 2 | 0 stop, 1 one tail pulse, 2 two tail pulses, 3 free-running |
| extra_dummy | input | XD_W | Dummy cycles added to the base read dummy |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_read | input | 1 | 1 for read data phase, 0 for write |
| req_quad | input | 1 | 1 runs all phases on four lines |
| req_addr_en | input | 1 | Include the address phase |
| req_cmd | input | CMD_W | Command byte |
| req_addr | input | ADDR_W | Address |
| req_len | input | LEN_W | Data byte count, 0 for none |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | Write byte consumed at this edge |
| rd_data | output | 8 | Assembled read byte |
| rd_valid | output | 1 | rd_data valid pulse |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| dq_o | output | 4 | Data lines out |
| dq_oe | output | 4 | Per-line output enable |
| dq_i | input | 4 | Data lines in |

## Verification
busy is due one system cycle after the accepting edge. cs_n falls at the next slot boundary, one or two cycles later. Each unit then takes two cycles, and rd_valid follows one cycle after the sampling edge that ends a byte. done shows up in the first cycle with busy low, after the hold slot and any tail pulses. The bench samples every output on the falling system-clock edge, in the middle of each half of the serial clock. It counts rising serial-clock edges inside and outside the chip-select frame, so it needs no fixed start offset. It drives read data in the low half, ahead of the unit it belongs to, and compares the counted units, hold length, tail count and captured bits against values worked out from the request.

// File: rtl/qram_pkg.sv
`timescale 1ns/1ps
package qram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALIGN, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_HOLD, ST_TAIL
  } qram_state_t;

  // serial clock periods needed to move a field on one or four lines
  function automatic int lane_units(int bits, logic quad);
    return quad ? (bits / 4) : bits;
  endfunction

  // stored dummy value is minus-one encoded
  function automatic int dummy_slots(int field, int extra);
    return field + 1 + extra;
  endfunction

endpackage

// File: rtl/qram_slot_clock.sv
`timescale 1ns/1ps
module qram_slot_clock (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic free_run,
  output logic slot_end,
  output logic sclk
);
  logic half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half <= 1'b0;
    else        half <= ~half;
  end

  // second half of each serial period ends the slot
  assign slot_end = half;
  assign sclk     = half & (run | free_run);

endmodule

// File: rtl/qram_shifter.sv
`timescale 1ns/1ps
module qram_shifter #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quad,
  input  logic              load_hdr,
  input  logic              load_byte,
  input  logic              shift_en,
  input  logic              cap_en,
  input  logic              byte_end,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic [3:0]        dq_i,
  output logic [3:0]        lane_out,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int SH_W = CMD_W + ADDR_W;

  logic [SH_W-1:0] tx;
  logic [7:0]      rx, rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx <= '0;
    else if (load_hdr)  tx <= {cmd, addr};
    else if (load_byte) tx <= {wr_data, {(SH_W-8){1'b0}}};
    else if (shift_en)  tx <= quad ? (tx << 4) : (tx << 1);
  end

  assign lane_out = quad ? tx[SH_W-1 -: 4] : {3'b000, tx[SH_W-1]};
  assign rx_next  = quad ? {rx[3:0], dq_i} : {rx[6:0], dq_i[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx       <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (cap_en) rx <= rx_next;
      if (cap_en && byte_end) begin
        rd_data  <= rx_next;
        rd_valid <= 1'b1;
      end
    end
  end

  // R6: a byte takes at least two serial periods, so valid never repeats
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/qram_seq.sv
`timescale 1ns/1ps
module qram_seq
  import qram_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 8,
  parameter int XD_W        = 3,
  parameter int DUMMY_FIELD = 5,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_end,
  input  logic             req_valid,
  input  logic             req_read,
  input  logic             req_quad,
  input  logic             req_addr_en,
  input  logic [LEN_W-1:0] req_len,
  input  logic [XD_W-1:0]  extra_dummy,
  input  logic [1:0]       clk_mode,
  output qram_state_t      st,
  output logic             quad_q,
  output logic             rd_q,
  output logic             accept,
  output logic             load_byte,
  output logic             shift_en,
  output logic             cap_en,
  output logic             byte_end,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt, ncnt, post_cnt;
  logic [LEN_W-1:0] left, nleft;
  logic [XD_W-1:0]  xd_q;
  logic             aen_q, fin, load_c;
  qram_state_t      nst, data_st, post_st;
  logic [CNT_W-1:0] cmd_m1, addr_m1, byte_m1, dum_m1;

  assign cmd_m1  = CNT_W'(lane_units(CMD_W, quad_q) - 1);
  assign addr_m1 = CNT_W'(lane_units(ADDR_W, quad_q) - 1);
  assign byte_m1 = CNT_W'(lane_units(8, quad_q) - 1);
  assign dum_m1  = CNT_W'(dummy_slots(DUMMY_FIELD, int'(xd_q)) - 1);

  assign accept = req_valid && (st == ST_IDLE);
  assign busy   = (st != ST_IDLE);

  always_comb begin
    data_st  = (left != '0) ? ST_DATA : ST_HOLD;
    post_st  = (rd_q && aen_q) ? ST_DUMMY : data_st;
    post_cnt = (rd_q && aen_q) ? dum_m1 : byte_m1;
    nst      = st;
    ncnt     = cnt - 1'b1;
    nleft    = left;
    fin      = 1'b0;
    load_c   = 1'b0;
    case (st)
      ST_ALIGN: begin nst = ST_CMD; ncnt = cmd_m1; end
      ST_CMD: if (cnt == '0) begin
        if (aen_q) begin nst = ST_ADDR; ncnt = addr_m1; end
        else begin
          nst = post_st; ncnt = post_cnt;
          load_c = (post_st == ST_DATA) && !rd_q;
        end
      end
      ST_ADDR: if (cnt == '0) begin
        nst = post_st; ncnt = post_cnt;
        load_c = (post_st == ST_DATA) && !rd_q;
      end
      ST_DUMMY: if (cnt == '0) begin nst = data_st; ncnt = byte_m1; end
      ST_DATA: if (cnt == '0) begin
        if (left == LEN_W'(1)) begin nst = ST_HOLD; nleft = '0; end
        else begin
          nleft = left - 1'b1; ncnt = byte_m1; load_c = !rd_q;
        end
      end
      ST_HOLD: begin
        if (clk_mode == 2'd1 || clk_mode == 2'd2) begin
          nst  = ST_TAIL;
          ncnt = (clk_mode == 2'd2) ? CNT_W'(1) : '0;
        end else fin = 1'b1;
      end
      ST_TAIL: if (cnt == '0) fin = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      left   <= '0;
      xd_q   <= '0;
      rd_q   <= 1'b0;
      quad_q <= 1'b0;
      aen_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st     <= ST_ALIGN;
        rd_q   <= req_read;
        quad_q <= req_quad;
        aen_q  <= req_addr_en;
        left   <= req_len;
        xd_q   <= extra_dummy;
      end else if (slot_end && st != ST_IDLE) begin
        st   <= fin ? ST_IDLE : nst;
        cnt  <= ncnt;
        left <= nleft;
        done <= fin;
      end
    end
  end

  assign load_byte = slot_end && load_c;
  assign shift_en  = slot_end && (st == ST_CMD || st == ST_ADDR ||
                                  (st == ST_DATA && !rd_q));
  assign cap_en    = slot_end && (st == ST_DATA) && rd_q;
  assign byte_end  = cap_en && (cnt == '0);

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);
  a_r11_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/quad_ram_engine.sv
`timescale 1ns/1ps
module quad_ram_engine
  import qram_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 8,
  parameter int XD_W        = 3,
  parameter int DUMMY_FIELD = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        clk_mode,
  input  logic [XD_W-1:0]   extra_dummy,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic              req_quad,
  input  logic              req_addr_en,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_i
);
  localparam int DUM_MAX  = DUMMY_FIELD + (1 << XD_W);
  localparam int UNIT_MAX = (ADDR_W > DUM_MAX) ? ADDR_W : DUM_MAX;
  localparam int CNT_W    = $clog2(UNIT_MAX + 1);

  qram_state_t st;
  logic quad_q, rd_q, accept, load_byte, shift_en, cap_en, byte_end;
  logic slot_end, run, drive;
  logic [3:0] lane_out;

  qram_seq #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .XD_W(XD_W),
    .DUMMY_FIELD(DUMMY_FIELD), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end),
    .req_valid(req_valid), .req_read(req_read), .req_quad(req_quad),
    .req_addr_en(req_addr_en), .req_len(req_len), .extra_dummy(extra_dummy),
    .clk_mode(clk_mode), .st(st), .quad_q(quad_q), .rd_q(rd_q),
    .accept(accept), .load_byte(load_byte), .shift_en(shift_en),
    .cap_en(cap_en), .byte_end(byte_end), .busy(busy), .done(done)
  );

  qram_shifter #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .quad(quad_q), .load_hdr(accept),
    .load_byte(load_byte), .shift_en(shift_en), .cap_en(cap_en),
    .byte_end(byte_end), .cmd(req_cmd), .addr(req_addr), .wr_data(wr_data),
    .dq_i(dq_i), .lane_out(lane_out), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign run = (st inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_TAIL});

  qram_slot_clock u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .free_run(clk_mode == 2'd3),
    .slot_end(slot_end), .sclk(sclk)
  );

  assign cs_n    = !(st inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_HOLD});
  assign drive   = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_DATA && !rd_q);
  assign dq_oe   = drive ? (quad_q ? 4'hF : 4'h1) : 4'h0;
  assign dq_o    = drive ? lane_out : 4'h0;
  assign wr_take = load_byte;

  a_r8_cs_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> !sclk);
  a_r9_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && clk_mode == 2'd0 |-> !sclk);
  a_r10_free_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    clk_mode == 2'd3 && $past(clk_mode) == 2'd3 |-> sclk != $past(sclk));
  a_r4_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> dq_oe == 4'h0);
  a_r5_take_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> busy && !cs_n);

endmodule

// File: tb/quad_ram_engine_bench.sv
`timescale 1ns/1ps
module quad_ram_engine_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [1:0] clk_mode;
  logic [2:0] extra_dummy;
  logic req_valid, req_read, req_quad, req_addr_en;
  logic [7:0] req_cmd;
  logic [23:0] req_addr;
  logic [7:0] req_len, wr_data, rd_data;
  logic wr_take, rd_valid, busy, done, cs_n, sclk;
  logic [3:0] dq_o, dq_oe, dq_i;

  quad_ram_engine u_quad_ram_engine (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .extra_dummy(extra_dummy),
    .req_valid(req_valid), .req_read(req_read), .req_quad(req_quad),
    .req_addr_en(req_addr_en), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int checks = 0, errors = 0;
  logic [3:0] cap_d [0:255];
  logic [3:0] cap_oe [0:255];
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];
  logic [7:0] rgot [0:15];
  int n, tail, lowrun, hold_seen, cs_falls, rcount, dones, widx;
  bit setup_ok, done_busy, prev_cs;
  bit t_quad, t_read;
  int t_len, t_start, upb;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint gather(int first, int bits, bit q);
    longint v = 0;
    int nu = q ? bits / 4 : bits;
    for (int i = 0; i < nu; i++)
      v = q ? ((v << 4) | longint'(cap_d[first+i])) : ((v << 1) | longint'(cap_d[first+i][0]));
    return v;
  endfunction

  // pin-level model of the memory, sampled mid-half
  initial begin
    n = 0; tail = 0; lowrun = 0; hold_seen = 0; cs_falls = 0; rcount = 0; dones = 0;
    prev_cs = 1'b1; dq_i = 4'h0; setup_ok = 1'b0; done_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (!cs_n && prev_cs) begin
        n = 0; tail = 0; lowrun = 0; cs_falls++;
        setup_ok = (sclk == 1'b0) && (dq_oe != 4'h0);
      end
      if (!cs_n) begin
        if (sclk) begin
          if (n < 256) begin cap_d[n] = dq_o; cap_oe[n] = dq_oe; end
          n++; lowrun = 0;
        end else begin
          lowrun++;
          if (t_read && n >= t_start && n < t_start + t_len * upb) begin
            int j, k;
            logic [7:0] b;
            j = n - t_start; b = rbuf[j / upb]; k = j % upb;
            dq_i = t_quad ? ((k == 0) ? b[7:4] : b[3:0]) : {2'b00, b[7-k], 1'b0};
          end
        end
      end
      if (cs_n && !prev_cs) hold_seen = lowrun;
      if (cs_n && sclk && busy) tail++;
      if (rd_valid) begin if (rcount < 16) rgot[rcount] = rd_data; rcount++; end
      if (done) begin dones++; done_busy = busy; end
      prev_cs = cs_n;
    end
  end

  // write-byte supplier: advance after the consuming edge
  initial begin
    forever begin
      @(negedge clk);
      if (wr_take) begin
        @(posedge clk); #1;
        widx++;
        wr_data = wbuf[widx & 15];
      end
    end
  end

  task automatic run_txn(input bit rd, input bit q, input bit aen, input int len,
                         input logic [1:0] mode, input logic [2:0] xd, input bit poke);
    logic [7:0] cmd;
    logic [23:0] addr;
    int cu, au, du, exp_units, falls0, tmo;
    cmd = 8'($urandom); addr = 24'($urandom);
    for (int i = 0; i < 16; i++) begin wbuf[i] = 8'($urandom); rbuf[i] = 8'($urandom); end
    t_quad = q; t_read = rd; t_len = len; upb = q ? 2 : 8;
    cu = q ? 2 : 8; au = aen ? (q ? 6 : 24) : 0; du = (rd && aen) ? 6 + int'(xd) : 0;
    t_start = cu + au + du;
    exp_units = t_start + len * upb + ((mode == 2'd3) ? 1 : 0);
    clk_mode = mode; extra_dummy = xd;
    widx = 0; wr_data = wbuf[0]; rcount = 0; dones = 0; falls0 = cs_falls;
    @(negedge clk);
    req_read = rd; req_quad = q; req_addr_en = aen; req_cmd = cmd; req_addr = addr;
    req_len = 8'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
    if (poke) begin
      req_cmd = ~cmd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    tmo = 0;
    while (dones == 0 && tmo < 3000) begin @(posedge clk); tmo++; end
    if (dones == 0) chk(1'b0, "R11 watchdog no done", 0, 1);
    repeat (12) @(posedge clk);
    chk(n == exp_units, "R7 unit count in frame", n, exp_units);
    chk(gather(0, 8, q) == longint'(cmd), q ? "R3 command" : "R2 command", gather(0, 8, q), cmd);
    chk(cap_oe[0] == (q ? 4'hF : 4'h1), q ? "R3 drive enable" : "R2 drive enable", cap_oe[0], q ? 15 : 1);
    if (aen)
      chk(gather(cu, 24, q) == longint'(addr), q ? "R3 address" : "R2 address", gather(cu, 24, q), addr);
    if (du > 0) begin
      bit z = 1'b1;
      for (int i = cu + au; i < t_start; i++) if (cap_oe[i] != 4'h0) z = 1'b0;
      chk(z, "R4 dummy lines released", z, 1);
    end
    if (!rd) begin
      chk(widx == len, "R5 write bytes taken", widx, len);
      for (int b = 0; b < len; b++)
        chk(gather(t_start + b * upb, 8, q) == longint'(wbuf[b]), "R5 write byte",
            gather(t_start + b * upb, 8, q), wbuf[b]);
    end else begin
      chk(rcount == len, "R6 read byte count", rcount, len);
      for (int b = 0; b < len && b < 16; b++)
        chk(rgot[b] == rbuf[b], "R6 read byte", rgot[b], rbuf[b]);
    end
    if (mode != 2'd3) begin
      chk(setup_ok, "R8 cs setup", setup_ok, 1);
      chk(hold_seen == 2, "R8 cs hold", hold_seen, 2);
    end
    chk(tail == ((mode == 2'd1) ? 1 : (mode == 2'd2) ? 2 : 0), "R9 tail pulses", tail,
        (mode == 2'd1) ? 1 : (mode == 2'd2) ? 2 : 0);
    chk(dones == 1 && !done_busy, "R11 done once with busy low", dones, 1);
    if (poke) chk(cs_falls - falls0 == 1, "R12 busy request ignored", cs_falls - falls0, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; clk_mode = 2'd0; extra_dummy = 3'd0; req_valid = 1'b0;
    req_read = 1'b0; req_quad = 1'b0; req_addr_en = 1'b0; req_cmd = '0;
    req_addr = '0; req_len = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && dq_oe == 4'h0 && !busy && !done && !rd_valid,
        "R1 reset state", {cs_n, sclk, busy, done, rd_valid}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_txn(1'b0, 1'b0, 1'b0, 0, 2'd0, 3'd0, 1'b0);  // R7 command only, SPI
    run_txn(1'b0, 1'b1, 1'b0, 0, 2'd1, 3'd0, 1'b0);  // R7 command only, QPI
    run_txn(1'b1, 1'b1, 1'b1, 4, 2'd0, 3'd0, 1'b0);  // R4 base dummy
    run_txn(1'b1, 1'b1, 1'b1, 3, 2'd2, 3'd7, 1'b0);  // R4 largest extra
    run_txn(1'b0, 1'b0, 1'b1, 3, 2'd1, 3'd0, 1'b0);  // R5 SPI write
    run_txn(1'b1, 1'b0, 1'b1, 2, 2'd0, 3'd2, 1'b0);  // R6 SPI read
    run_txn(1'b0, 1'b1, 1'b1, 5, 2'd0, 3'd0, 1'b1);  // R12 poke while busy
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 6; i++) begin @(negedge clk); if (sclk) quiet = 1'b0; end
      chk(quiet, "R9 idle clock stopped", quiet, 1);
    end
    run_txn(1'b0, 1'b1, 1'b1, 2, 2'd3, 3'd0, 1'b0);  // R10 free clock
    begin
      bit alt = 1'b1;
      logic last;
      @(negedge clk); last = sclk;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (sclk == last) alt = 1'b0; last = sclk; end
      chk(alt, "R10 idle clock toggles", alt, 1);
    end
    for (int t = 0; t < 30; t++)
      run_txn(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 7),
              2'($urandom), 3'($urandom), 1'($urandom % 4 == 0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired R11 actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule